// File: doc/BRIEF.md
# OFDM Frame Airtime Calculator

This block works out how many microseconds an OFDM frame holds the medium. The caller supplies three things: the frame length in bytes, the bitrate in steps of 100 kbit/s, and a channel bandwidth mode. The block then returns the total duration with a one-cycle valid strobe. The total covers the interframe space (SIFS), the preamble, and a whole number of OFDM symbols. That symbol count is enough to carry the service/tail overhead bits plus the payload.

The bandwidth mode sets the timing constants. In the narrow modes it also reduces the effective bitrate. The symbol count is a rounded-up quotient, produced by a sequential restoring divider that yields one quotient bit per clock. A request is accepted with a single-cycle `start` pulse. While a computation runs, `busy` stays high and further `start` pulses are dropped. A zero bitrate is reported at once as an error and no division takes place.

Top module: `airtime_calc`

## Requirements
- R1: After synchronous reset, `busy`, `valid` and `err` are low and `duration` is 0.
- R2: With `bw_mode` = 0 (20 MHz) and `band_5g` = 0, duration = 10 + 20 + 4·S, where S = ceil(((22 + 8·len)·10) / (rate·4)).
- R3: With `bw_mode` = 0 and `band_5g` = 1, the SIFS term becomes 16 µs. All other terms are as in R2.
- R4: With `bw_mode` = 1 (40 MHz), SIFS is 8 µs and the preamble is 14 µs. `band_5g` has no effect.
- R5: With `bw_mode` = 2 (10 MHz), SIFS is 32 µs and the rate used is ceil(rate/2). `band_5g` has no effect.
- R6: With `bw_mode` = 3 (5 MHz), SIFS is 64 µs and the rate used is ceil(rate/4). `band_5g` has no effect.
- R7: The symbol count rounds up. A bit total that divides exactly adds no extra symbol.
- R8: For a nonzero rate, `valid` rises exactly LEN_W+9 clock edges after the edge that accepts `start` (21 at defaults), with `err` low. `busy` is high from the accepting edge until `valid` rises.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The result and the latency are those of the request already in progress.
- R10: A `start` with `rate` = 0 raises `valid` and `err` together on the accepting edge. `duration` is then 0 and `busy` stays low.
- R11: `duration` holds its value in every cycle in which `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when not busy |
| frame_len | input | LEN_W (12) | Frame length in bytes |
| rate | input | RATE_W (10) | Bitrate in 100 kbit/s units |
| bw_mode | input | 2 | 0: 20 MHz, 1: 40 MHz, 2: 10 MHz, 3: 5 MHz |
| band_5g | input | 1 | Selects the 5 GHz SIFS in 20 MHz mode |
| busy | output | 1 | Computation in progress |
| valid | output | 1 | One-cycle result strobe |
| err | output | 1 | Result rejected because the rate was zero |
| duration | output | LEN_W+11 (23) | Airtime in microseconds |

## Verification
Faults inside the block show up at the ports in two ways. A divider that steps too often or too rarely moves the `valid` strobe away from its fixed latency on the very first request. A wrong quotient bit, remainder, or ceiling carry changes `duration` on the vector that uses it. Wrong mode constants or a wrong rate scaling offset every result in one mode by the same term. These appear within one sweep pass of the affected mode. A state register that re-arms while busy changes both the reported latency and the result of the next request.

// File: rtl/airtime_pkg.sv
package airtime_pkg;

    typedef enum logic [1:0] {
        BW_20 = 2'd0,
        BW_40 = 2'd1,
        BW_10 = 2'd2,
        BW_05 = 2'd3
    } bw_mode_e;

    localparam int TIME_W = 7;
    localparam int SYM_W  = 3;

    localparam logic [TIME_W-1:0] SIFS_BG_US    = 7'd10;
    localparam logic [TIME_W-1:0] SIFS_5G_US    = 7'd16;
    localparam logic [TIME_W-1:0] SIFS_WIDE_US  = 7'd8;
    localparam logic [TIME_W-1:0] SIFS_HALF_US  = 7'd32;
    localparam logic [TIME_W-1:0] SIFS_QUART_US = 7'd64;
    localparam logic [TIME_W-1:0] PRE_US        = 7'd20;
    localparam logic [TIME_W-1:0] PRE_SHORT_US  = 7'd14;
    localparam logic [SYM_W-1:0]  SYM_US        = 3'd4;
    localparam int                OVH_BITS      = 22;

    typedef struct packed {
        logic [TIME_W-1:0] sifs;
        logic [TIME_W-1:0] pre;
        logic [SYM_W-1:0]  sym;
    } timing_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } calc_state_e;

endpackage

// File: rtl/airtime_mode_sel.sv
module airtime_mode_sel
    import airtime_pkg::*;
#(
    parameter int RATE_W = 10
) (
    input  bw_mode_e          mode,
    input  logic              band_5g,
    input  logic [RATE_W-1:0] rate,
    output timing_t           tim,
    output logic [RATE_W-1:0] eff_rate
);
    logic [RATE_W:0] half_up;
    logic [RATE_W:0] quart_up;

    assign half_up  = ({1'b0, rate} + (RATE_W+1)'(1)) >> 1;
    assign quart_up = ({1'b0, rate} + (RATE_W+1)'(3)) >> 2;

    always_comb begin
        tim.sym  = SYM_US;
        tim.pre  = PRE_US;
        tim.sifs = band_5g ? SIFS_5G_US : SIFS_BG_US;
        eff_rate = rate;
        unique case (mode)
            BW_40: begin
                tim.sifs = SIFS_WIDE_US;
                tim.pre  = PRE_SHORT_US;
            end
            BW_10: begin
                tim.sifs = SIFS_HALF_US;
                eff_rate = half_up[RATE_W-1:0];
            end
            BW_05: begin
                tim.sifs = SIFS_QUART_US;
                eff_rate = quart_up[RATE_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/airtime_divider.sv
module airtime_divider #(
    parameter int NUM_W = 20,
    parameter int DVS_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [NUM_W-1:0] quotient,
    output logic [DVS_W:0]   remainder
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DVS_W-1:0] dvs_q;
    logic [CNT_W-1:0] step_q;
    logic             run_q;
    logic [DVS_W:0]   shifted;
    logic [DVS_W+1:0] trial;

    assign shifted = {remainder[DVS_W-1:0], quotient[NUM_W-1]};
    assign trial   = {1'b0, shifted} - {2'b00, dvs_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            done      <= 1'b0;
            step_q    <= '0;
            dvs_q     <= '0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            if (load && !run_q) begin
                run_q     <= 1'b1;
                step_q    <= '0;
                dvs_q     <= divisor;
                quotient  <= dividend;
                remainder <= '0;
            end else if (run_q) begin
                if (!trial[DVS_W+1]) begin
                    remainder <= trial[DVS_W:0];
                    quotient  <= {quotient[NUM_W-2:0], 1'b1};
                end else begin
                    remainder <= shifted;
                    quotient  <= {quotient[NUM_W-2:0], 1'b0};
                end
                if (step_q == CNT_W'(NUM_W - 1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
                step_q <= step_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/airtime_calc.sv
module airtime_calc
    import airtime_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int RATE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [RATE_W-1:0]   rate,
    input  logic [1:0]          bw_mode,
    input  logic                band_5g,
    output logic                busy,
    output logic                valid,
    output logic                err,
    output logic [LEN_W+10:0]   duration
);
    localparam int BITS_W = LEN_W + 4;
    localparam int NUM_W  = BITS_W + 4;
    localparam int DVS_W  = RATE_W + SYM_W;
    localparam int DUR_W  = NUM_W + 3;

    timing_t           tim;
    logic [RATE_W-1:0] eff_rate;
    logic [BITS_W-1:0] bit_total;
    logic [NUM_W-1:0]  numer;
    logic [DVS_W-1:0]  denom;
    logic              accept;
    logic              div_done;
    logic [NUM_W-1:0]  quo;
    logic [DVS_W:0]    rem;
    logic [NUM_W-1:0]  sym_count;
    calc_state_e       state_q;
    logic [TIME_W:0]   base_q;
    logic [SYM_W-1:0]  sym_q;

    airtime_mode_sel #(.RATE_W(RATE_W)) u_mode (
        .mode     (bw_mode_e'(bw_mode)),
        .band_5g  (band_5g),
        .rate     (rate),
        .tim      (tim),
        .eff_rate (eff_rate)
    );

    assign bit_total = BITS_W'(OVH_BITS) + (BITS_W'(frame_len) << 3);
    assign numer     = NUM_W'(bit_total) * NUM_W'(10);
    assign denom     = DVS_W'(eff_rate) * DVS_W'(tim.sym);
    assign accept    = start && (state_q == ST_IDLE) && (rate != '0);

    airtime_divider #(.NUM_W(NUM_W), .DVS_W(DVS_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .dividend  (numer),
        .divisor   (denom),
        .done      (div_done),
        .quotient  (quo),
        .remainder (rem)
    );

    assign sym_count = quo + NUM_W'(rem != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            valid    <= 1'b0;
            err      <= 1'b0;
            duration <= '0;
            base_q   <= '0;
            sym_q    <= '0;
        end else begin
            valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && rate == '0) begin
                        valid    <= 1'b1;
                        err      <= 1'b1;
                        duration <= '0;
                    end else if (accept) begin
                        state_q <= ST_RUN;
                        base_q  <= {1'b0, tim.sifs} + {1'b0, tim.pre};
                        sym_q   <= tim.sym;
                    end
                end
                ST_RUN: begin
                    if (div_done) begin
                        state_q  <= ST_IDLE;
                        valid    <= 1'b1;
                        err      <= 1'b0;
                        duration <= DUR_W'(base_q) + DUR_W'(sym_q) * DUR_W'(sym_count);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/airtime_calc_chk.sv
module airtime_calc_chk #(
    parameter int RATE_W = 10,
    parameter int DUR_W  = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [RATE_W-1:0] rate,
    input logic              busy,
    input logic              valid,
    input logic              err,
    input logic [DUR_W-1:0]  duration
);
    p_hold_dur_r11: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(duration));

    p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (valid && err) |-> (!busy && duration == '0));

    p_zero_rate_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && rate == '0) |=> (valid && err && !busy));

    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && rate != '0) |=> busy);

    p_end_valid_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (valid && !err));

    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !valid);

    p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || (valid && !err)));
endmodule

bind airtime_calc airtime_calc_chk #(.RATE_W(RATE_W), .DUR_W(DUR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rate     (rate),
    .busy     (busy),
    .valid    (valid),
    .err      (err),
    .duration (duration)
);

// File: tb/airtime_calc_tb.sv
module airtime_calc_tb_top;
    localparam int LEN_W  = 12;
    localparam int RATE_W = 10;
    localparam int DUR_W  = LEN_W + 11;
    localparam int LAT    = LEN_W + 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  frame_len = '0;
    logic [RATE_W-1:0] rate = '0;
    logic [1:0]        bw_mode = '0;
    logic              band_5g = 1'b0;
    logic              busy, valid, err;
    logic [DUR_W-1:0]  duration;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done_run = 1'b0;

    always #10 clk = ~clk;

    airtime_calc #(.LEN_W(LEN_W), .RATE_W(RATE_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
        .rate(rate), .bw_mode(bw_mode), .band_5g(band_5g),
        .busy(busy), .valid(valid), .err(err), .duration(duration)
    );

    function automatic int exp_dur(int len, int r, int mode, int b5);
        int sifs = (b5 != 0) ? 16 : 10;
        int pre  = 20;
        int er   = r;
        int num, bps;
        if (mode == 1) begin sifs = 8;  pre = 14; end
        if (mode == 2) begin sifs = 32; er = (r + 1) / 2; end
        if (mode == 3) begin sifs = 64; er = (r + 3) / 4; end
        num = (22 + 8 * len) * 10;
        bps = er * 4;
        return sifs + pre + 4 * ((num + bps - 1) / bps);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic string req_of(int mode, int b5);
        if (mode == 1) return "R4";
        if (mode == 2) return "R5";
        if (mode == 3) return "R6";
        return (b5 != 0) ? "R3" : "R2";
    endfunction

    task automatic run(int len, int r, int mode, int b5, bit disturb, string req);
        int n = 0;
        int expv;
        int hold;
        expv = (r == 0) ? 0 : exp_dur(len, r, mode, b5);
        @(negedge clk);
        frame_len = LEN_W'(len); rate = RATE_W'(r);
        bw_mode = 2'(mode); band_5g = b5[0]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!valid && n < 4 * LAT) begin
            if (disturb && n == 3) begin
                start = 1'b1; frame_len = '1; rate = '0; bw_mode = 2'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (r == 0) begin
            check(n == 0 && err, "R10", "error latency", n, 0);
            check(duration == '0, "R10", "error duration", int'(duration), 0);
        end else begin
            check(n == LAT && !err, disturb ? "R9" : "R8", "latency", n, LAT);
            check(int'(duration) == expv, req, "duration", int'(duration), expv);
            hold = int'(duration);
            @(negedge clk);
            @(negedge clk);
            check(int'(duration) == hold && !valid, "R11", "hold", int'(duration), hold);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done_run) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int rates[13] = '{1, 2, 3, 5, 6, 7, 60, 90, 120, 240, 360, 540, 1023};
        int lens[7]   = '{0, 1, 10, 14, 100, 1500, 4095};
        repeat (3) @(negedge clk);
        check(!busy && !valid && !err && duration == '0, "R1", "reset outputs",
              int'(duration), 0);
        rst = 1'b0;
        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 2; b++)
                for (int ri = 0; ri < 13; ri++)
                    for (int li = 0; li < 7; li++)
                        run(lens[li], rates[ri], m, b, 1'b0, req_of(m, b));
        // R7: 30 bits at 1.5 Mbit/s divide exactly (5 symbols), 38 bits do not
        run(1, 15, 0, 0, 1'b0, "R7");
        check(int'(duration) == 50, "R7", "exact division", int'(duration), 50);
        run(2, 15, 0, 0, 1'b0, "R7");
        check(int'(duration) == 58, "R7", "round up", int'(duration), 58);
        // R10: zero rate in every mode
        for (int m = 0; m < 4; m++) run(100, 0, m, 0, 1'b0, "R10");
        // R9: start pulses during busy are dropped
        run(1500, 540, 0, 0, 1'b1, "R9");
        run(14, 7, 3, 1, 1'b1, "R9");
        run(4095, 1, 2, 0, 1'b1, "R9");
        done_run = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule